// File: doc/BRIEF.md
# Precommit-Gated Load/Store Unit

This block sits between an in-order issue point and a single-request memory bus. It takes one memory instruction at a time. Each instruction carries a reorder-buffer tag, a store flag, an address and (for stores) write data. The unit turns it into at most one bus request and then returns a tagged result. Ordinary loads may go to the bus at once, before it is known that they will commit. Stores, and loads into a configurable I/O address window, are held back until the commit logic presents a precommit for that same tag.

Each precommit carries a side-effects-enabled bit. When that bit is set, the held access is released to the bus. When it is clear, the instruction is known to lie behind an exception. If its request has not yet gone out, the unit drops the request and reports completion with a zero result and no bus traffic. A request the bus has already accepted always runs to its response, so that no stale read data is left on the bus. A build option makes every load wait for precommit, as if all of memory were I/O space. This is meant for debugging.

Top module: `lsu_precommit_gate`

## Requirements
- R1: While reset is held and in the cycle after it is released, `in_ready` is 1, and `mem_req_valid` and `res_valid` are 0.
- R2: A load whose address is outside the I/O window raises `mem_req_valid` in the cycle after it is accepted, without any precommit, and keeps it raised until `mem_req_ready` is seen.
- R3: A store raises `mem_req_valid` only in a cycle where `pc_valid` is 1, `pc_rob` equals its tag and `pc_fx` is 1. In that cycle the request is raised combinationally.
- R4: A load is an I/O load when `(addr & IO_MASK) == IO_BASE` (by default, address bits 31:28 all ones). An I/O load is gated exactly like a store.
- R5: A precommit whose tag differs from the held instruction's tag neither releases nor squashes that instruction.
- R6: A precommit with matching tag and `pc_fx` = 0, arriving while the request has not been accepted by the bus, produces no bus request. One cycle later it produces `res_valid` with `res_data` = 0 and `res_err` = 0.
- R7: After the bus accepts a request, precommit inputs are ignored and the unit waits for `mem_rsp_valid`. A load result carries `mem_rsp_data`, a store result carries data 0, and `res_err` copies `mem_rsp_err`.
- R8: `res_valid` is a single-cycle pulse. It appears in the cycle after the response (or the squash) and carries the instruction's tag on `res_rob`. `in_ready` is 1 again in the cycle after the pulse.
- R9: With `ALL_LOADS_GATED` = 1, every load, whatever its address, waits for a matching precommit with `pc_fx` = 1 before `mem_req_valid` rises.
- R10: At most one request is outstanding. `mem_req_valid` stays 0 while a response is awaited, and `in_ready` stays 0 from acceptance until the result pulse.
- R11: A request presents the accepted instruction's address and write data on `mem_req_addr` and `mem_req_wdata`, with `mem_req_we` equal to its store flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit empty and able to accept |
| in_store | input | 1 | 1 = store, 0 = load |
| in_addr | input | ADDR_W | Access address |
| in_wdata | input | DATA_W | Store data |
| in_rob | input | ROB_W | Reorder-buffer tag |
| pc_valid | input | 1 | Precommit present this cycle |
| pc_rob | input | ROB_W | Tag of the precommitting instruction |
| pc_fx | input | 1 | 1 = side effects enabled, 0 = squash |
| mem_req_valid | output | 1 | Bus request valid |
| mem_req_ready | input | 1 | Bus takes the request |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | ADDR_W | Request address |
| mem_req_wdata | output | DATA_W | Request write data |
| mem_rsp_valid | input | 1 | Bus response present |
| mem_rsp_data | input | DATA_W | Response read data |
| mem_rsp_err | input | 1 | Response error flag |
| res_valid | output | 1 | Result pulse |
| res_rob | output | ROB_W | Result tag |
| res_data | output | DATA_W | Result data |
| res_err | output | 1 | Result error flag |

## Verification
The most serious fault is a controller that thinks a request has not been sent. It would show up within one cycle as a second `mem_req_valid`, or as a zero squash result while the bus still owes a response. Faulty gating shows up as soon as a store or I/O load is accepted: a request appears in the first cycle after acceptance, with no precommit present. A tag-compare or squash fault shows up one cycle after the precommit. Either a result pulse is missing or extra, or a request is raised when a squash was asked for.

// File: rtl/lsu_precommit_gate_pkg.sv
package lsu_precommit_gate_pkg;

   // Controller phases of the single instruction slot
   typedef enum logic [1:0] {
      PH_EMPTY = 2'd0,   // nothing held, accepting
      PH_HOLD  = 2'd1,   // held, request not yet taken by the bus
      PH_WAIT  = 2'd2,   // request taken, awaiting response
      PH_DONE  = 2'd3    // result presented for one cycle
   } lsu_phase_e;

   // Result source selected when the result register loads
   typedef enum logic [1:0] {
      RS_NONE   = 2'd0,
      RS_SQUASH = 2'd1,
      RS_BUS    = 2'd2
   } lsu_rsrc_e;

endpackage

// File: rtl/lsu_pg_classify.sv
module lsu_pg_classify #(
   parameter int               ADDR_W          = 32,
   parameter logic [ADDR_W-1:0] IO_BASE        = '0,
   parameter logic [ADDR_W-1:0] IO_MASK        = '0,
   parameter bit               ALL_LOADS_GATED = 1'b0
) (
   input  logic              is_store,
   input  logic [ADDR_W-1:0] addr,
   output logic              needs_commit
);

   logic in_window;
   logic load_gate;

   assign in_window = (addr & IO_MASK) == IO_BASE;

   generate
      if (ALL_LOADS_GATED) begin : g_all_loads
         // every load treated as I/O space
         assign load_gate = in_window | 1'b1;
      end else begin : g_window_loads
         assign load_gate = in_window;
      end
   endgenerate

   assign needs_commit = is_store | load_gate;

endmodule

// File: rtl/lsu_pg_slot.sv
module lsu_pg_slot #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int ROB_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              d_store,
   input  logic [ADDR_W-1:0] d_addr,
   input  logic [DATA_W-1:0] d_wdata,
   input  logic [ROB_W-1:0]  d_rob,
   output logic              q_store,
   output logic [ADDR_W-1:0] q_addr,
   output logic [DATA_W-1:0] q_wdata,
   output logic [ROB_W-1:0]  q_rob
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_store <= 1'b0;
         q_addr  <= '0;
         q_wdata <= '0;
         q_rob   <= '0;
      end else if (load) begin
         q_store <= d_store;
         q_addr  <= d_addr;
         q_wdata <= d_wdata;
         q_rob   <= d_rob;
      end
   end

endmodule

// File: rtl/lsu_pg_ctrl.sv
module lsu_pg_ctrl
   import lsu_precommit_gate_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      in_valid,
   input  logic      needs_commit,
   input  logic      pc_hit,
   input  logic      pc_fx,
   input  logic      bus_ready,
   input  logic      bus_rsp,
   output logic      accept,
   output logic      in_ready,
   output logic      bus_req,
   output logic      done,
   output lsu_rsrc_e rsrc
);

   lsu_phase_e phase, phase_nx;
   logic       held;
   logic       release_ok;
   logic       squash;
   logic       took_rsp;

   assign held       = phase == PH_HOLD;
   assign in_ready   = phase == PH_EMPTY;
   assign accept     = in_ready & in_valid;
   // squash only while the bus has not taken the request
   assign squash     = held & pc_hit & ~pc_fx;
   assign release_ok = ~needs_commit | (pc_hit & pc_fx);
   assign bus_req    = held & release_ok & ~squash;
   assign took_rsp   = (phase == PH_WAIT) & bus_rsp;
   assign done       = phase == PH_DONE;

   always_comb begin
      if (squash)        rsrc = RS_SQUASH;
      else if (took_rsp) rsrc = RS_BUS;
      else               rsrc = RS_NONE;
   end

   always_comb begin
      phase_nx = phase;
      case (phase)
         PH_EMPTY: if (accept) phase_nx = PH_HOLD;
         PH_HOLD: begin
            if (squash)                    phase_nx = PH_DONE;
            else if (bus_req && bus_ready) phase_nx = PH_WAIT;
         end
         PH_WAIT:  if (bus_rsp) phase_nx = PH_DONE;
         PH_DONE:  phase_nx = PH_EMPTY;
         default:  phase_nx = PH_EMPTY;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) phase <= PH_EMPTY;
      else        phase <= phase_nx;
   end

endmodule

// File: rtl/lsu_pg_result.sv
module lsu_pg_result
   import lsu_precommit_gate_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  lsu_rsrc_e         rsrc,
   input  logic              was_store,
   input  logic [DATA_W-1:0] bus_data,
   input  logic              bus_err,
   output logic [DATA_W-1:0] r_data,
   output logic              r_err
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         r_data <= '0;
         r_err  <= 1'b0;
      end else begin
         case (rsrc)
            RS_SQUASH: begin
               r_data <= '0;
               r_err  <= 1'b0;
            end
            RS_BUS: begin
               r_data <= was_store ? '0 : bus_data;
               r_err  <= bus_err;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/lsu_precommit_gate.sv
module lsu_precommit_gate
   import lsu_precommit_gate_pkg::*;
#(
   parameter int                ADDR_W          = 32,
   parameter int                DATA_W          = 32,
   parameter int                ROB_W           = 6,
   parameter logic [ADDR_W-1:0] IO_BASE         = {4'hF, {(ADDR_W-4){1'b0}}},
   parameter logic [ADDR_W-1:0] IO_MASK         = {4'hF, {(ADDR_W-4){1'b0}}},
   parameter bit                ALL_LOADS_GATED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              in_store,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [DATA_W-1:0] in_wdata,
   input  logic [ROB_W-1:0]  in_rob,
   input  logic              pc_valid,
   input  logic [ROB_W-1:0]  pc_rob,
   input  logic              pc_fx,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_we,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [DATA_W-1:0] mem_req_wdata,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_data,
   input  logic              mem_rsp_err,
   output logic              res_valid,
   output logic [ROB_W-1:0]  res_rob,
   output logic [DATA_W-1:0] res_data,
   output logic              res_err
);

   generate
      if (ADDR_W < 4) begin : g_bad_addr_w
         $error("ADDR_W must be at least 4");
      end
      if (DATA_W < 1) begin : g_bad_data_w
         $error("DATA_W must be positive");
      end
      if (ROB_W < 1) begin : g_bad_rob_w
         $error("ROB_W must be positive");
      end
      if ((IO_BASE & ~IO_MASK) != '0) begin : g_bad_window
         $error("IO_BASE has bits outside IO_MASK");
      end
   endgenerate

   logic              accept;
   logic              needs_commit;
   logic              pc_hit;
   logic              s_store;
   logic [ADDR_W-1:0] s_addr;
   logic [DATA_W-1:0] s_wdata;
   logic [ROB_W-1:0]  s_rob;
   lsu_rsrc_e         rsrc;

   lsu_pg_slot #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .ROB_W  (ROB_W)
   ) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .d_store (in_store),
      .d_addr  (in_addr),
      .d_wdata (in_wdata),
      .d_rob   (in_rob),
      .q_store (s_store),
      .q_addr  (s_addr),
      .q_wdata (s_wdata),
      .q_rob   (s_rob)
   );

   lsu_pg_classify #(
      .ADDR_W          (ADDR_W),
      .IO_BASE         (IO_BASE),
      .IO_MASK         (IO_MASK),
      .ALL_LOADS_GATED (ALL_LOADS_GATED)
   ) u_classify (
      .is_store     (s_store),
      .addr         (s_addr),
      .needs_commit (needs_commit)
   );

   assign pc_hit = pc_valid & (pc_rob == s_rob);

   lsu_pg_ctrl u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .needs_commit (needs_commit),
      .pc_hit       (pc_hit),
      .pc_fx        (pc_fx),
      .bus_ready    (mem_req_ready),
      .bus_rsp      (mem_rsp_valid),
      .accept       (accept),
      .in_ready     (in_ready),
      .bus_req      (mem_req_valid),
      .done         (res_valid),
      .rsrc         (rsrc)
   );

   lsu_pg_result #(
      .DATA_W (DATA_W)
   ) u_result (
      .clk       (clk),
      .rst_n     (rst_n),
      .rsrc      (rsrc),
      .was_store (s_store),
      .bus_data  (mem_rsp_data),
      .bus_err   (mem_rsp_err),
      .r_data    (res_data),
      .r_err     (res_err)
   );

   assign mem_req_we    = s_store;
   assign mem_req_addr  = s_addr;
   assign mem_req_wdata = s_wdata;
   assign res_rob       = s_rob;

endmodule

// File: rtl/lsu_precommit_gate_chk.sv
module lsu_precommit_gate_chk #(
   parameter int                ADDR_W          = 32,
   parameter int                DATA_W          = 32,
   parameter int                ROB_W           = 6,
   parameter logic [ADDR_W-1:0] IO_BASE         = '0,
   parameter logic [ADDR_W-1:0] IO_MASK         = '0,
   parameter bit                ALL_LOADS_GATED = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic [ROB_W-1:0]  in_rob,
   input logic [ADDR_W-1:0] in_addr,
   input logic              pc_valid,
   input logic [ROB_W-1:0]  pc_rob,
   input logic              pc_fx,
   input logic              mem_req_valid,
   input logic              mem_req_ready,
   input logic              mem_req_we,
   input logic [ADDR_W-1:0] mem_req_addr,
   input logic              mem_rsp_valid,
   input logic              res_valid,
   input logic [ROB_W-1:0]  res_rob,
   input logic [DATA_W-1:0] res_data,
   input logic              res_err
);

   logic              busy;
   logic              outst;
   logic [ROB_W-1:0]  cur_rob;
   logic [ADDR_W-1:0] cur_addr;
   logic              pc_match;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         outst    <= 1'b0;
         cur_rob  <= '0;
         cur_addr <= '0;
      end else begin
         if (in_valid && in_ready) begin
            busy     <= 1'b1;
            cur_rob  <= in_rob;
            cur_addr <= in_addr;
         end else if (res_valid) begin
            busy <= 1'b0;
         end
         if (mem_req_valid && mem_req_ready) outst <= 1'b1;
         else if (mem_rsp_valid)             outst <= 1'b0;
      end
   end

   assign pc_match = pc_valid && (pc_rob == cur_rob);

   // R3
   a_r3_store_waits: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_we) |-> (pc_match && pc_fx));

   // R4
   a_r4_io_load_waits: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && ((mem_req_addr & IO_MASK) == IO_BASE)) |-> (pc_match && pc_fx));

   // R6
   a_r6_squash_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !outst && !res_valid && pc_match && !pc_fx)
      |=> (res_valid && res_data == '0 && !res_err));

   // R6: no request in the squash cycle
   a_r6_squash_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !outst && pc_match && !pc_fx) |-> !mem_req_valid);

   // R8
   a_r8_rsp_to_result: assert property (@(posedge clk) disable iff (!rst_n)
      (outst && mem_rsp_valid) |=> (res_valid && res_rob == cur_rob));

   // R8
   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> (!res_valid && in_ready));

   // R10
   a_r10_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      outst |-> !mem_req_valid);

   // R10
   a_r10_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !in_ready);

   // R11
   a_r11_req_addr: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (busy && mem_req_addr == cur_addr));

   // R9
   a_r9_all_loads_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (ALL_LOADS_GATED && mem_req_valid) |-> (pc_match && pc_fx));

endmodule

bind lsu_precommit_gate lsu_precommit_gate_chk #(
   .ADDR_W          (ADDR_W),
   .DATA_W          (DATA_W),
   .ROB_W           (ROB_W),
   .IO_BASE         (IO_BASE),
   .IO_MASK         (IO_MASK),
   .ALL_LOADS_GATED (ALL_LOADS_GATED)
) u_chk (.*);

// File: tb/lsu_precommit_gate_tb.sv
`timescale 1ns/1ps
module lsu_precommit_gate_tb;

   localparam int ADDR_W = 32;
   localparam int DATA_W = 32;
   localparam int ROB_W  = 6;

   typedef struct packed {
      logic        st;
      logic [31:0] addr;
      logic [31:0] wdata;
      logic [1:0]  pcm;     // 0 none, 1 match fx=1, 2 match fx=0, 3 other tag fx=1
      logic [31:0] rsp;
      logic        err;
      logic        exp_req;
      logic [31:0] exp_data;
      logic        exp_err;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VEC [NV] = '{
      '{st:1'b0, addr:32'h0000_1000, wdata:32'h0, pcm:2'd0, rsp:32'h1111_0001, err:1'b0, exp_req:1'b1, exp_data:32'h1111_0001, exp_err:1'b0},
      '{st:1'b0, addr:32'h0000_2000, wdata:32'h0, pcm:2'd1, rsp:32'hA5A5_A5A5, err:1'b1, exp_req:1'b1, exp_data:32'hA5A5_A5A5, exp_err:1'b1},
      '{st:1'b0, addr:32'h0000_3000, wdata:32'h0, pcm:2'd2, rsp:32'h0,         err:1'b0, exp_req:1'b0, exp_data:32'h0,         exp_err:1'b0},
      '{st:1'b1, addr:32'h0000_4000, wdata:32'h1234_5678, pcm:2'd0, rsp:32'h0, err:1'b0, exp_req:1'b0, exp_data:32'h0,         exp_err:1'b0},
      '{st:1'b1, addr:32'h0000_5000, wdata:32'h9ABC_DEF0, pcm:2'd1, rsp:32'hDEAD_0000, err:1'b0, exp_req:1'b1, exp_data:32'h0, exp_err:1'b0},
      '{st:1'b1, addr:32'h0000_5004, wdata:32'h0000_0001, pcm:2'd3, rsp:32'h0, err:1'b0, exp_req:1'b0, exp_data:32'h0,         exp_err:1'b0},
      '{st:1'b1, addr:32'h0000_5008, wdata:32'h0000_0002, pcm:2'd2, rsp:32'h0, err:1'b0, exp_req:1'b0, exp_data:32'h0,         exp_err:1'b0},
      '{st:1'b0, addr:32'hF000_0010, wdata:32'h0, pcm:2'd0, rsp:32'h0,         err:1'b0, exp_req:1'b0, exp_data:32'h0,         exp_err:1'b0},
      '{st:1'b0, addr:32'hF000_0020, wdata:32'h0, pcm:2'd1, rsp:32'hCAFE_F00D, err:1'b0, exp_req:1'b1, exp_data:32'hCAFE_F00D, exp_err:1'b0},
      '{st:1'b0, addr:32'hF123_0000, wdata:32'h0, pcm:2'd3, rsp:32'h0,         err:1'b0, exp_req:1'b0, exp_data:32'h0,         exp_err:1'b0},
      '{st:1'b1, addr:32'hF000_0030, wdata:32'h0BAD_0BAD, pcm:2'd1, rsp:32'h5555_5555, err:1'b1, exp_req:1'b1, exp_data:32'h0, exp_err:1'b1},
      '{st:1'b0, addr:32'hEFFF_FFFC, wdata:32'h0, pcm:2'd0, rsp:32'h0000_0077, err:1'b0, exp_req:1'b1, exp_data:32'h0000_0077, exp_err:1'b0},
      '{st:1'b0, addr:32'hF000_0000, wdata:32'h0, pcm:2'd0, rsp:32'h0,         err:1'b0, exp_req:1'b0, exp_data:32'h0,         exp_err:1'b0}
   };

   logic              clk = 1'b0;
   logic              rst_n;
   logic              in_valid, in_valid2;
   logic              in_store;
   logic [ADDR_W-1:0] in_addr;
   logic [DATA_W-1:0] in_wdata;
   logic [ROB_W-1:0]  in_rob;
   logic              pc_valid, pc_fx;
   logic [ROB_W-1:0]  pc_rob;
   logic              mem_req_ready;
   logic              mem_rsp_valid, mem_rsp_err;
   logic [DATA_W-1:0] mem_rsp_data;

   logic              in_ready, mem_req_valid, mem_req_we, res_valid, res_err;
   logic [ADDR_W-1:0] mem_req_addr;
   logic [DATA_W-1:0] mem_req_wdata, res_data;
   logic [ROB_W-1:0]  res_rob;

   logic              in_ready2, mem_req_valid2, mem_req_we2, res_valid2, res_err2;
   logic [ADDR_W-1:0] mem_req_addr2;
   logic [DATA_W-1:0] mem_req_wdata2, res_data2;
   logic [ROB_W-1:0]  res_rob2;

   int nchk  = 0;
   int nfail = 0;

   always #4 clk = ~clk;

   lsu_precommit_gate u_dut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_store(in_store),
      .in_addr(in_addr), .in_wdata(in_wdata), .in_rob(in_rob),
      .pc_valid(pc_valid), .pc_rob(pc_rob), .pc_fx(pc_fx),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
      .res_valid(res_valid), .res_rob(res_rob), .res_data(res_data), .res_err(res_err)
   );

   lsu_precommit_gate #(.ALL_LOADS_GATED(1'b1)) u_dut_all (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid2), .in_ready(in_ready2), .in_store(in_store),
      .in_addr(in_addr), .in_wdata(in_wdata), .in_rob(in_rob),
      .pc_valid(pc_valid), .pc_rob(pc_rob), .pc_fx(pc_fx),
      .mem_req_valid(mem_req_valid2), .mem_req_ready(mem_req_ready),
      .mem_req_we(mem_req_we2), .mem_req_addr(mem_req_addr2), .mem_req_wdata(mem_req_wdata2),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
      .res_valid(res_valid2), .res_rob(res_rob2), .res_data(res_data2), .res_err(res_err2)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic offer(input logic st, input logic [31:0] a, input logic [31:0] wd,
                        input logic [ROB_W-1:0] rob, input bit second);
      @(negedge clk);
      in_store = st; in_addr = a; in_wdata = wd; in_rob = rob;
      if (second) in_valid2 = 1'b1; else in_valid = 1'b1;
   endtask

   task automatic apply_vec(input int i);
      vec_t v;
      logic [ROB_W-1:0] rob;
      string tag;
      bit io;
      v   = VEC[i];
      rob = ROB_W'(i + 8);
      io  = (v.addr & 32'hF000_0000) == 32'hF000_0000;
      if (v.pcm == 2'd2)      tag = "R6";
      else if (v.pcm == 2'd3) tag = "R5";
      else if (v.st)          tag = "R3";
      else if (io)            tag = "R4";
      else                    tag = "R2";

      offer(v.st, v.addr, v.wdata, rob, 1'b0);
      @(negedge clk);
      in_valid = 1'b0;
      pc_valid = (v.pcm != 2'd0);
      pc_rob   = (v.pcm == 2'd3) ? rob + 1'b1 : rob;
      pc_fx    = (v.pcm != 2'd2);
      #1;
      chk(mem_req_valid == v.exp_req, tag, 32'(mem_req_valid), 32'(v.exp_req));
      chk(in_ready == 1'b0, "R10 busy", 32'(in_ready), 32'd0);
      if (v.exp_req) begin
         chk(mem_req_addr == v.addr, "R11 addr", mem_req_addr, v.addr);
         chk(mem_req_we == v.st, "R11 we", 32'(mem_req_we), 32'(v.st));
         if (v.st) chk(mem_req_wdata == v.wdata, "R11 wdata", mem_req_wdata, v.wdata);
         @(negedge clk);
         pc_valid = 1'b0;
         mem_rsp_valid = 1'b1; mem_rsp_data = v.rsp; mem_rsp_err = v.err;
         #1;
         chk(res_valid == 1'b0, "R8 early", 32'(res_valid), 32'd0);
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         #1;
         chk(res_valid == 1'b1, "R8 pulse", 32'(res_valid), 32'd1);
         chk(res_data == v.exp_data, "R7 data", res_data, v.exp_data);
         chk(res_err == v.exp_err, "R7 err", 32'(res_err), 32'(v.exp_err));
         chk(res_rob == rob, "R8 tag", 32'(res_rob), 32'(rob));
      end else if (v.pcm == 2'd2) begin
         @(negedge clk);
         pc_valid = 1'b0;
         #1;
         chk(res_valid == 1'b1, "R6 pulse", 32'(res_valid), 32'd1);
         chk(res_data == 32'h0, "R6 data", res_data, 32'h0);
         chk(res_err == 1'b0, "R6 err", 32'(res_err), 32'd0);
      end else begin
         @(negedge clk);
         pc_valid = 1'b1; pc_rob = rob; pc_fx = 1'b0;
         #1;
         chk(mem_req_valid == 1'b0, "R6 no req", 32'(mem_req_valid), 32'd0);
         chk(res_valid == 1'b0, "R5 no result", 32'(res_valid), 32'd0);
         @(negedge clk);
         pc_valid = 1'b0;
         #1;
         chk(res_valid == 1'b1, "R6 pulse", 32'(res_valid), 32'd1);
         chk(res_data == 32'h0, "R6 data", res_data, 32'h0);
         chk(res_rob == rob, "R8 tag", 32'(res_rob), 32'(rob));
      end
      @(negedge clk);
      #1;
      chk(res_valid == 1'b0, "R8 one cycle", 32'(res_valid), 32'd0);
      chk(in_ready == 1'b1, "R8 ready", 32'(in_ready), 32'd1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_valid2 = 1'b0;
      in_store = 1'b0; in_addr = '0; in_wdata = '0; in_rob = '0;
      pc_valid = 1'b0; pc_rob = '0; pc_fx = 1'b0;
      mem_req_ready = 1'b1; mem_rsp_valid = 1'b0; mem_rsp_data = '0; mem_rsp_err = 1'b0;

      // R1: reset state
      repeat (3) @(negedge clk);
      #1;
      chk(in_ready == 1'b1, "R1 ready in reset", 32'(in_ready), 32'd1);
      chk(mem_req_valid == 1'b0, "R1 req in reset", 32'(mem_req_valid), 32'd0);
      chk(res_valid == 1'b0, "R1 res in reset", 32'(res_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(in_ready == 1'b1 && mem_req_valid == 1'b0 && res_valid == 1'b0,
          "R1 after reset", {29'd0, in_ready, mem_req_valid, res_valid}, 32'h4);

      for (int i = 0; i < NV; i++) apply_vec(i);

      // R7: squash after the bus has taken the request is ignored
      offer(1'b0, 32'h0000_6000, 32'h0, 6'd50, 1'b0);
      @(negedge clk);
      in_valid = 1'b0;
      #1;
      chk(mem_req_valid == 1'b1, "R2 issue", 32'(mem_req_valid), 32'd1);
      @(negedge clk);
      pc_valid = 1'b1; pc_rob = 6'd50; pc_fx = 1'b0;
      #1;
      chk(mem_req_valid == 1'b0, "R10 no second req", 32'(mem_req_valid), 32'd0);
      chk(res_valid == 1'b0, "R7 squash ignored", 32'(res_valid), 32'd0);
      @(negedge clk);
      pc_valid = 1'b0;
      mem_rsp_valid = 1'b1; mem_rsp_data = 32'h0000_BEEF; mem_rsp_err = 1'b1;
      #1;
      chk(res_valid == 1'b0, "R7 still waiting", 32'(res_valid), 32'd0);
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      #1;
      chk(res_valid == 1'b1, "R7 pulse", 32'(res_valid), 32'd1);
      chk(res_data == 32'h0000_BEEF, "R7 data", res_data, 32'h0000_BEEF);
      chk(res_err == 1'b1, "R7 err", 32'(res_err), 32'd1);
      @(negedge clk);

      // R2: request held while the bus is not ready
      offer(1'b0, 32'h0000_7000, 32'h0, 6'd51, 1'b0);
      @(negedge clk);
      in_valid = 1'b0; mem_req_ready = 1'b0;
      #1;
      chk(mem_req_valid == 1'b1, "R2 stall cycle 1", 32'(mem_req_valid), 32'd1);
      @(negedge clk);
      #1;
      chk(mem_req_valid == 1'b1, "R2 stall cycle 2", 32'(mem_req_valid), 32'd1);
      chk(mem_req_addr == 32'h0000_7000, "R11 addr stable", mem_req_addr, 32'h0000_7000);
      mem_req_ready = 1'b1;
      @(negedge clk);
      #1;
      chk(mem_req_valid == 1'b0, "R10 after accept", 32'(mem_req_valid), 32'd0);
      mem_rsp_valid = 1'b1; mem_rsp_data = 32'h0000_0055; mem_rsp_err = 1'b0;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      #1;
      chk(res_valid == 1'b1 && res_data == 32'h0000_0055, "R8 stalled result", res_data, 32'h0000_0055);
      @(negedge clk);

      // R9: every load gated when the option is set
      offer(1'b0, 32'h0000_1000, 32'h0, 6'd40, 1'b1);
      @(negedge clk);
      in_valid2 = 1'b0;
      #1;
      chk(mem_req_valid2 == 1'b0, "R9 load held", 32'(mem_req_valid2), 32'd0);
      @(negedge clk);
      pc_valid = 1'b1; pc_rob = 6'd41; pc_fx = 1'b1;
      #1;
      chk(mem_req_valid2 == 1'b0, "R9 other tag", 32'(mem_req_valid2), 32'd0);
      @(negedge clk);
      pc_rob = 6'd40;
      #1;
      chk(mem_req_valid2 == 1'b1, "R9 released", 32'(mem_req_valid2), 32'd1);
      chk(mem_req_valid == 1'b0, "R9 idle unit quiet", 32'(mem_req_valid), 32'd0);
      @(negedge clk);
      pc_valid = 1'b0;
      mem_rsp_valid = 1'b1; mem_rsp_data = 32'h0000_0099; mem_rsp_err = 1'b0;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      #1;
      chk(res_valid2 == 1'b1 && res_data2 == 32'h0000_0099, "R9 result", res_data2, 32'h0000_0099);
      chk(res_valid == 1'b0, "R9 idle unit no result", 32'(res_valid), 32'd0);
      @(negedge clk);
      #1;
      chk(in_ready2 == 1'b1, "R8 ready again", 32'(in_ready2), 32'd1);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule